// File: doc/BRIEF.md
# Video Resizer Step Parameter Calculator

This block turns a requested picture resize into the configuration words a hardware resizer consumes. A controller presents a source width and height, a destination width and height, and a chroma sampling format, then pulses `start`. The block checks the request, packs the two size words and the control word, and computes four step words: luma horizontal, luma vertical, chroma horizontal and chroma vertical. When all words are final it pulses `done`.

Each step word is a 16.16 fixed-point ratio. Its encoding depends on the direction of the resize. Unity scaling gives zero. An upscale keeps only the fractional quotient. A downscale carries the integer ratio in the upper half and the fractional quotient in the lower half. The chroma source dimensions are first reduced according to the sampling format. The chroma steps then use these reduced dimensions against the full destination size.

One restoring divider is shared by all four step computations, which run one after another. Any step whose source and destination lengths are equal skips the divider. A request outside the legal range raises an error flag and leaves every previously produced word untouched.

Top module: `scl_step_calc`

## Requirements
- R1: On success, `src_size` holds `{src_h-1, src_w-1}` and `dst_size` holds `{dst_h-1, dst_w-1}`, with the height in bits [31:16] and the width in bits [15:0].
- R2: On success, `ctrl_word` carries the format code in bits [4:3] and zero in every other bit. The codes are 0 = 4:2:0, 1 = 4:2:2 and 2 = 4:4:4.
- R3: A step word whose source length equals its destination length is zero.
- R4: When the source length is below the destination length, a step word's bits [15:0] hold floor(src*65536/dst) and bits [31:16] are zero.
- R5: When the source length is above the destination length, a step word's bits [31:16] hold floor(src/dst) and bits [15:0] hold the low 16 bits of floor(src*65536/dst).
- R6: The chroma steps use a chroma source of (src_w/2, src_h/2) for 4:2:0, (src_w/2, src_h) for 4:2:2 and (src_w, src_h) for 4:4:4, each against the full destination size. The halving truncates.
- R7: `err` is set when, in either direction, dst > 8*src or src > 8*dst. Ratios of exactly 8 or exactly 1/8 are accepted.
- R8: `err` is set when either destination dimension is zero or when the format code is 3.
- R9: A request that sets `err` still ends in a `done` pulse. It leaves `src_size`, `dst_size`, `ctrl_word` and all four step words at their previous values. A successful request clears `err`.
- R10: `busy` is high from the cycle after an accepted start until `done`. `done` lasts exactly one cycle. All output words stay unchanged from `done` until the next accepted start.
- R11: A `start` that arrives while `busy` is high is ignored, together with the inputs presented alongside it.
- R12: After reset, every output word is zero and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation with the present inputs |
| src_w | input | 16 | Source width in pixels |
| src_h | input | 16 | Source height in lines |
| dst_w | input | 16 | Destination width in pixels |
| dst_h | input | 16 | Destination height in lines |
| fmt | input | 2 | Chroma format: 0 = 4:2:0, 1 = 4:2:2, 2 = 4:4:4 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |
| src_size | output | 32 | Packed source size word |
| dst_size | output | 32 | Packed destination size word |
| ctrl_word | output | 32 | Control word with the format field |
| luma_h_step | output | 32 | Luma horizontal step |
| luma_v_step | output | 32 | Luma vertical step |
| chroma_h_step | output | 32 | Chroma horizontal step |
| chroma_v_step | output | 32 | Chroma vertical step |

## Verification
The bench builds the block with its defaults: 16-bit dimensions, a 16-bit fraction and a ratio limit of 8. This makes every divide a full 32-iteration pass and lets full-HD sizes be used directly. The vectors land exactly on the 8x and 1/8 ratio boundaries and one pixel beyond them. They cover exact integer downscales, such as 3x with a zero fraction, and odd sources whose chroma halving truncates to one pixel. With these sizes a downscale quotient needs more than 16 bits, so the upper half of a step word is exercised with real values.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int SCL_DIM_W      = 16;
    localparam int SCL_FRAC_W     = 16;
    localparam int SCL_MAX_RATIO  = 8;
    localparam int SCL_CTRL_W     = 32;
    localparam int SCL_FMT_LSB    = 3;

    localparam int STEP_NUM       = 4;
    localparam logic [1:0] STEP_LUMA_H   = 2'd0;
    localparam logic [1:0] STEP_LUMA_V   = 2'd1;
    localparam logic [1:0] STEP_CHROMA_H = 2'd2;
    localparam logic [1:0] STEP_CHROMA_V = 2'd3;

    typedef enum logic [1:0] {
        FMT_420  = 2'd0,
        FMT_422  = 2'd1,
        FMT_444  = 2'd2,
        FMT_RSVD = 2'd3
    } chroma_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOAD,
        ST_DIV
    } calc_state_e;

    function automatic logic halves_width(chroma_fmt_e f);
        return (f == FMT_420) || (f == FMT_422);
    endfunction

    function automatic logic halves_height(chroma_fmt_e f);
        return (f == FMT_420);
    endfunction

endpackage

// File: rtl/scl_divider.sv
module scl_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             valid,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W  = $clog2(NUM_W + 1);
    localparam int PROD_W = NUM_W + DEN_W + 1;

    logic [DEN_W:0]   rem_q;
    logic [NUM_W-1:0] quot_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] num_keep;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             valid_q;

    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W:0]   rem_nxt;
    logic [NUM_W-1:0] quot_nxt;

    always_comb begin
        trial    = {rem_q[DEN_W-1:0], quot_q[NUM_W-1]};
        fits     = (trial >= {1'b0, den_q});
        rem_nxt  = fits ? (trial - {1'b0, den_q}) : trial;
        quot_nxt = {quot_q[NUM_W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= '0;
            quot_q   <= '0;
            den_q    <= '0;
            num_keep <= '0;
            cnt_q    <= '0;
            busy_q   <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (load && !busy_q) begin
                rem_q    <= '0;
                quot_q   <= num;
                den_q    <= den;
                num_keep <= num;
                cnt_q    <= CNT_W'(NUM_W);
                busy_q   <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= rem_nxt;
                quot_q <= quot_nxt;
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign busy  = busy_q;
    assign valid = valid_q;
    assign quot  = quot_q;

    // quotient and remainder reconstruct the dividend (R4, R5)
    assert_div_exact_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ((PROD_W'(quot_q) * PROD_W'(den_q) + PROD_W'(rem_q)) == PROD_W'(num_keep)));

    assert_div_rem_R4: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (rem_q < {1'b0, den_q}));

    assert_div_load_idle_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> !busy_q);

endmodule

// File: rtl/scl_validate.sv
module scl_validate
    import scl_pkg::*;
#(
    parameter int DIM_W     = 16,
    parameter int MAX_RATIO = 8
) (
    input  logic [DIM_W-1:0] src_w,
    input  logic [DIM_W-1:0] src_h,
    input  logic [DIM_W-1:0] dst_w,
    input  logic [DIM_W-1:0] dst_h,
    input  logic [1:0]       fmt,
    output logic             err
);
    localparam int EXT_W = DIM_W + $clog2(MAX_RATIO + 1) + 1;

    logic [DIM_W-1:0] src_ax [2];
    logic [DIM_W-1:0] dst_ax [2];
    logic [1:0]       axis_bad;

    assign src_ax[0] = src_w;
    assign src_ax[1] = src_h;
    assign dst_ax[0] = dst_w;
    assign dst_ax[1] = dst_h;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [EXT_W-1:0] src_lim;
        logic [EXT_W-1:0] dst_lim;
        always_comb begin
            src_lim     = EXT_W'(src_ax[a]) * EXT_W'(MAX_RATIO);
            dst_lim     = EXT_W'(dst_ax[a]) * EXT_W'(MAX_RATIO);
            axis_bad[a] = (dst_ax[a] == '0)
                        || (EXT_W'(dst_ax[a]) > src_lim)
                        || (EXT_W'(src_ax[a]) > dst_lim);
        end
    end

    assign err = (|axis_bad) || (chroma_fmt_e'(fmt) == FMT_RSVD);

endmodule

// File: rtl/scl_step_calc.sv
module scl_step_calc
    import scl_pkg::*;
#(
    parameter int DIM_W     = SCL_DIM_W,
    parameter int FRAC_W    = SCL_FRAC_W,
    parameter int MAX_RATIO = SCL_MAX_RATIO
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [DIM_W-1:0]         src_w,
    input  logic [DIM_W-1:0]         src_h,
    input  logic [DIM_W-1:0]         dst_w,
    input  logic [DIM_W-1:0]         dst_h,
    input  logic [1:0]               fmt,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic [2*DIM_W-1:0]       src_size,
    output logic [2*DIM_W-1:0]       dst_size,
    output logic [SCL_CTRL_W-1:0]    ctrl_word,
    output logic [DIM_W+FRAC_W-1:0]  luma_h_step,
    output logic [DIM_W+FRAC_W-1:0]  luma_v_step,
    output logic [DIM_W+FRAC_W-1:0]  chroma_h_step,
    output logic [DIM_W+FRAC_W-1:0]  chroma_v_step
);
    localparam int STEP_W = DIM_W + FRAC_W;
    localparam int SIZE_W = 2 * DIM_W;

    typedef struct packed {
        logic [DIM_W-1:0] h;
        logic [DIM_W-1:0] w;
    } dims_t;

    calc_state_e      state_q;
    dims_t            src_q;
    dims_t            dst_q;
    chroma_fmt_e      fmt_q;
    logic [1:0]       phase_q;
    logic             done_q;
    logic             err_q;
    logic [SIZE_W-1:0]     src_size_q;
    logic [SIZE_W-1:0]     dst_size_q;
    logic [SCL_CTRL_W-1:0] ctrl_q;
    logic [STEP_W-1:0]     step_q [STEP_NUM];

    dims_t            chroma_src;
    logic [DIM_W-1:0] op_src;
    logic [DIM_W-1:0] op_dst;
    logic             op_unity;
    logic             req_bad;
    logic             div_load;
    logic             div_busy;
    logic             div_valid;
    logic [STEP_W-1:0] div_quot;
    logic             step_wr;
    logic [STEP_W-1:0] step_val;
    logic             last_phase;

    scl_validate #(
        .DIM_W     (DIM_W),
        .MAX_RATIO (MAX_RATIO)
    ) u_validate (
        .src_w (src_q.w),
        .src_h (src_q.h),
        .dst_w (dst_q.w),
        .dst_h (dst_q.h),
        .fmt   (fmt_q),
        .err   (req_bad)
    );

    always_comb begin
        chroma_src.w = halves_width(fmt_q)  ? (src_q.w >> 1) : src_q.w;
        chroma_src.h = halves_height(fmt_q) ? (src_q.h >> 1) : src_q.h;
        unique case (phase_q)
            STEP_LUMA_H:   begin op_src = src_q.w;      op_dst = dst_q.w; end
            STEP_LUMA_V:   begin op_src = src_q.h;      op_dst = dst_q.h; end
            STEP_CHROMA_H: begin op_src = chroma_src.w; op_dst = dst_q.w; end
            default:       begin op_src = chroma_src.h; op_dst = dst_q.h; end
        endcase
        op_unity   = (op_src == op_dst);
        last_phase = (phase_q == STEP_CHROMA_V);
        div_load   = (state_q == ST_LOAD) && !op_unity;
        step_wr    = ((state_q == ST_LOAD) && op_unity) || ((state_q == ST_DIV) && div_valid);
        step_val   = (state_q == ST_DIV) ? div_quot : '0;
    end

    scl_divider #(
        .NUM_W (STEP_W),
        .DEN_W (DIM_W)
    ) u_divider (
        .clk   (clk),
        .rst   (rst),
        .load  (div_load),
        .num   ({op_src, FRAC_W'(0)}),
        .den   (op_dst),
        .busy  (div_busy),
        .valid (div_valid),
        .quot  (div_quot)
    );

    for (genvar i = 0; i < STEP_NUM; i++) begin : g_step
        always_ff @(posedge clk) begin
            if (rst) begin
                step_q[i] <= '0;
            end else if (step_wr && (phase_q == 2'(i))) begin
                step_q[i] <= step_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            src_q      <= '0;
            dst_q      <= '0;
            fmt_q      <= FMT_420;
            phase_q    <= STEP_LUMA_H;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            src_size_q <= '0;
            dst_size_q <= '0;
            ctrl_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        src_q   <= '{h: src_h, w: src_w};
                        dst_q   <= '{h: dst_h, w: dst_w};
                        fmt_q   <= chroma_fmt_e'(fmt);
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (req_bad) begin
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        err_q      <= 1'b0;
                        src_size_q <= {src_q.h - 1'b1, src_q.w - 1'b1};
                        dst_size_q <= {dst_q.h - 1'b1, dst_q.w - 1'b1};
                        ctrl_q     <= SCL_CTRL_W'(fmt_q) << SCL_FMT_LSB;
                        phase_q    <= STEP_LUMA_H;
                        state_q    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (op_unity) begin
                        if (last_phase) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            phase_q <= phase_q + 1'b1;
                        end
                    end else begin
                        state_q <= ST_DIV;
                    end
                end
                default: begin
                    if (div_valid) begin
                        if (last_phase) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            phase_q <= phase_q + 1'b1;
                            state_q <= ST_LOAD;
                        end
                    end
                end
            endcase
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign done          = done_q;
    assign err           = err_q;
    assign src_size      = src_size_q;
    assign dst_size      = dst_size_q;
    assign ctrl_word     = ctrl_q;
    assign luma_h_step   = step_q[STEP_LUMA_H];
    assign luma_v_step   = step_q[STEP_LUMA_V];
    assign chroma_h_step = step_q[STEP_CHROMA_H];
    assign chroma_v_step = step_q[STEP_CHROMA_V];

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_busy_excl_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done_q);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start) |=>
            ($stable(step_q[0]) && $stable(step_q[1]) && $stable(step_q[2]) &&
             $stable(step_q[3]) && $stable(src_size_q) && $stable(dst_size_q) &&
             $stable(ctrl_q) && $stable(err_q)));

    assert_err_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (done_q && err_q) |->
            ($stable(step_q[0]) && $stable(step_q[1]) && $stable(step_q[2]) &&
             $stable(step_q[3]) && $stable(src_size_q) && $stable(ctrl_q)));

    assert_unity_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (done_q && !err_q && (src_q.w == dst_q.w)) |-> (step_q[STEP_LUMA_H] == '0));

    assert_no_div_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !div_busy);

endmodule

// File: tb/test_scl_step_calc.sv
module test_scl_step_calc;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    localparam int WAIT_MAX = 2000;

    // {src_w, src_h, dst_w, dst_h, fmt, expected err}
    localparam logic [66:0] VEC [NVEC] = '{
        {16'd100,  16'd100,  16'd100, 16'd100, 2'd0, 1'b0},
        {16'd320,  16'd240,  16'd640, 16'd480, 2'd1, 1'b0},
        {16'd1920, 16'd1080, 16'd640, 16'd360, 2'd2, 1'b0},
        {16'd100,  16'd50,   16'd800, 16'd400, 2'd0, 1'b0},
        {16'd100,  16'd100,  16'd801, 16'd100, 2'd0, 1'b1},
        {16'd800,  16'd400,  16'd100, 16'd50,  2'd1, 1'b0},
        {16'd801,  16'd100,  16'd100, 16'd100, 2'd2, 1'b1},
        {16'd100,  16'd100,  16'd100, 16'd100, 2'd3, 1'b1},
        {16'd100,  16'd100,  16'd0,   16'd100, 2'd0, 1'b1},
        {16'd1000, 16'd300,  16'd700, 16'd900, 2'd1, 1'b0},
        {16'd3,    16'd5,    16'd7,   16'd2,   2'd0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [15:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
    logic [1:0]  fmt = '0;
    logic busy, done, err;
    logic [31:0] src_size, dst_size, ctrl_word;
    logic [31:0] luma_h_step, luma_v_step, chroma_h_step, chroma_v_step;

    int total = 0;
    int fails = 0;
    logic [31:0] prev [7];

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_step_calc i_scl_step_calc (
        .clk(clk), .rst(rst), .start(start),
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h), .fmt(fmt),
        .busy(busy), .done(done), .err(err),
        .src_size(src_size), .dst_size(dst_size), .ctrl_word(ctrl_word),
        .luma_h_step(luma_h_step), .luma_v_step(luma_v_step),
        .chroma_h_step(chroma_h_step), .chroma_v_step(chroma_v_step)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_step(input int unsigned s, input int unsigned d);
        longint unsigned q;
        if (s == d) return 32'h0;
        q = ({32'h0, s} << 16) / longint'(d);
        if (s < d) return {16'h0, q[15:0]};
        return {16'(s / d), q[15:0]};
    endfunction

    function automatic string dir_tag(input int unsigned s, input int unsigned d);
        if (s == d) return "R3";
        if (s < d) return "R4";
        return "R5";
    endfunction

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < WAIT_MAX) begin
            @(negedge clk);
            n++;
        end
        if (done !== 1'b1) begin
            total++;
            fails++;
            $display("FAIL R10: actual no done expected done within %0d cycles", WAIT_MAX);
        end
    endtask

    task automatic launch(input int unsigned sw, sh, dw, dh, input logic [1:0] f);
        @(negedge clk);
        src_w = 16'(sw); src_h = 16'(sh); dst_w = 16'(dw); dst_h = 16'(dh); fmt = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after start", {31'h0, busy}, 32'h1);
    endtask

    task automatic check_ok(input int unsigned sw, sh, dw, dh, input logic [1:0] f);
        int unsigned cw, ch;
        cw = (f == 2'd2) ? sw : sw / 2;
        ch = (f == 2'd0) ? sh / 2 : sh;
        chk("R9 err clear", {31'h0, err}, 32'h0);
        chk("R1 src_size", src_size, {16'(sh - 1), 16'(sw - 1)});
        chk("R1 dst_size", dst_size, {16'(dh - 1), 16'(dw - 1)});
        chk("R2 ctrl_word", ctrl_word, 32'(f) << 3);
        chk({dir_tag(sw, dw), " luma_h"}, luma_h_step, exp_step(sw, dw));
        chk({dir_tag(sh, dh), " luma_v"}, luma_v_step, exp_step(sh, dh));
        chk("R6 chroma_h", chroma_h_step, exp_step(cw, dw));
        chk("R6 chroma_v", chroma_v_step, exp_step(ch, dh));
        prev[0] = src_size; prev[1] = dst_size; prev[2] = ctrl_word;
        prev[3] = exp_step(sw, dw); prev[4] = exp_step(sh, dh);
        prev[5] = exp_step(cw, dw); prev[6] = exp_step(ch, dh);
    endtask

    task automatic check_kept(input string tag);
        chk({tag, " src_size"}, src_size, prev[0]);
        chk({tag, " dst_size"}, dst_size, prev[1]);
        chk({tag, " ctrl_word"}, ctrl_word, prev[2]);
        chk({tag, " luma_h"}, luma_h_step, prev[3]);
        chk({tag, " luma_v"}, luma_v_step, prev[4]);
        chk({tag, " chroma_h"}, chroma_h_step, prev[5]);
        chk({tag, " chroma_v"}, chroma_v_step, prev[6]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 7; i++) prev[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 busy", {31'h0, busy}, 32'h0);
        chk("R12 done", {31'h0, done}, 32'h0);
        chk("R12 err", {31'h0, err}, 32'h0);
        chk("R12 src_size", src_size, 32'h0);
        chk("R12 ctrl_word", ctrl_word, 32'h0);
        chk("R12 luma_h", luma_h_step, 32'h0);
        chk("R12 chroma_v", chroma_v_step, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            int unsigned sw, sh, dw, dh;
            logic [1:0] f;
            logic e;
            sw = VEC[i][66:51]; sh = VEC[i][50:35];
            dw = VEC[i][34:19]; dh = VEC[i][18:3];
            f = VEC[i][2:1]; e = VEC[i][0];
            launch(sw, sh, dw, dh, f);
            wait_done();
            chk("R7 R8 err flag", {31'h0, err}, {31'h0, e});
            if (e) check_kept("R9");
            else check_ok(sw, sh, dw, dh, f);
            @(negedge clk);
            chk("R10 done single", {31'h0, done}, 32'h0);
        end

        // R11: start during busy with other inputs is ignored
        launch(640, 480, 320, 240, 2'd2);
        repeat (10) @(negedge clk);
        src_w = 16'd16; src_h = 16'd16; dst_w = 16'd16; dst_h = 16'd16; fmt = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R11 luma_h", luma_h_step, exp_step(640, 320));
        chk("R11 src_size", src_size, {16'd479, 16'd639});
        check_ok(640, 480, 320, 240, 2'd2);
        // R10: outputs held after done with no start
        repeat (6) @(negedge clk);
        chk("R10 busy idle", {31'h0, busy}, 32'h0);
        check_kept("R10 hold");

        // R9: rejected request after success keeps words, next success clears err
        launch(50, 50, 0, 0, 2'd1);
        wait_done();
        chk("R9 err set", {31'h0, err}, 32'h1);
        check_kept("R9 after ok");
        launch(64, 64, 64, 64, 2'd2);
        wait_done();
        check_ok(64, 64, 64, 64, 2'd2);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule